// File: doc/BRIEF.md
# Sixteen-Bit Shared-Bus Multi-Step Processor

This block is a small processor core. Its eight general registers, a result register and the operand register all meet on one 16-bit internal bus. A control state machine decides, in every clock, which source drives that bus and which register captures it.

An instruction word is presented on `instr_i` while `run_i` is held high. The machine latches the word and then steps through the transfers the opcode needs:

- A move or move-top completes in one execute step.
- An add or subtract takes three execute steps. The first stages the destination in the operand register, the second computes into the result register, and the third writes back.

`done_o` marks the final step. The shared bus is brought out on `bus_o` so that the data of each transfer can be seen at the boundary.

The block is meant to be fed by an instruction source that advances when `done_o` pulses. Memory access, branching and external I/O are outside its scope.

Top module: `busproc16`

## Requirements
- R1: An active-low asynchronous `rst_n` returns the machine to the fetch step, clears all eight general registers and the internal operand and result registers to zero, and holds `done_o` low. This applies even in the middle of an instruction.
- R2: While in the fetch step with `run_i` low, the machine stays in fetch, `done_o` stays low and no general register changes, whatever `instr_i` carries.
- R3: The instruction word is split into fields as follows:
  - bits 15:13 are the opcode;
  - bit 12 is the immediate flag;
  - bits 11:9 are the destination register rX;
  - bits 2:0 are the source register rY;
  - with the flag set, bits 8:0 are a 9-bit constant.
- R4: Opcode 000 with the flag clear copies rY into rX. `done_o` is high in the first clock after the fetch edge, and `bus_o` shows the value written in that clock.
- R5: Opcode 000 with the flag set writes the 9-bit constant, zero-extended to 16 bits, into rX in one execute step. The word 0x101C leaves r0 equal to 0x001C.
- R6: Opcode 001 writes bits 7:0 of the word into bits 15:8 of rX and zero into bits 7:0, in one execute step. Bit 8 of the word has no effect.
- R7: Opcode 010 adds, modulo 2^16, either rY or the zero-extended constant to rX. It takes three execute steps:
  - in the first, `bus_o` shows the old rX;
  - `done_o` is low in the first two and high in the third;
  - in the third, `bus_o` shows the sum.
- R8: Opcode 011 behaves as opcode 010 but computes rX minus the operand in two's complement, wrapping modulo 2^16.
- R9: An instruction changes only its destination register; the other seven general registers keep their values.
- R10: After the step with `done_o` high, the machine returns to fetch and accepts the next instruction under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start request, sampled in the fetch step |
| instr_i | input | 16 | Instruction word, captured in the fetch step |
| done_o | output | 1 | High during the final step of an instruction |
| bus_o | output | 16 | Value on the internal shared bus |

## Verification
The assertions assume that `run_i` and `instr_i` are settled before each rising edge. They also assume that the opcode is one of the four defined codes, since the write-back and step-count properties only describe those. The stimulus changes inputs only on falling edges and uses only opcodes 000 to 011. It drops `run_i` right after the fetch edge so that a word is never fetched twice. Registers are read back through moves of a register onto itself, which place the value on the bus.

// File: rtl/busproc_pkg.sv
package busproc_pkg;
  localparam int WORD_W = 16;
  localparam int REG_N  = 8;
  localparam int REG_AW = $clog2(REG_N);
  localparam int SEL_W  = 4;
  localparam int IMM_W  = 9;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_MOVE = 3'b000,
    OP_MOVT = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011
  } opcode_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EX1   = 2'd1,
    ST_EX2   = 2'd2,
    ST_EX3   = 2'd3
  } step_e;

  // bus source codes: 0..REG_N-1 are general registers
  localparam logic [SEL_W-1:0] SEL_GREG   = 4'd8;
  localparam logic [SEL_W-1:0] SEL_IMM9   = 4'd9;
  localparam logic [SEL_W-1:0] SEL_IMMTOP = 4'd10;

  function automatic logic [WORD_W-1:0] imm_zext(input logic [IMM_W-1:0] d);
    return {{(WORD_W-IMM_W){1'b0}}, d};
  endfunction

  function automatic logic [WORD_W-1:0] imm_top(input logic [BYTE_W-1:0] d);
    return {d, {(WORD_W-BYTE_W){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] alu_fn(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic              sub);
    logic [WORD_W-1:0] opnd;
    opnd = sub ? ~b : b;
    return a + opnd + {{(WORD_W-1){1'b0}}, sub};
  endfunction
endpackage

// File: rtl/busproc_regbank.sv
module busproc_regbank
  import busproc_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = REG_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en_i,
  input  logic [W-1:0]        bus_i,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_o[k] <= '0;
      else if (wr_en_i[k]) regs_o[k] <= bus_i;
    end

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i[k] |=> $stable(regs_o[k]));
  end
endmodule

// File: rtl/busproc_alu.sv
module busproc_alu
  import busproc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_load_i,
  input  logic         g_load_i,
  input  logic         sub_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] g_o
);
  logic [W-1:0] a_q;
  logic [W-1:0] result;

  assign result = alu_fn(a_q, bus_i, sub_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      g_o <= '0;
    end else begin
      if (a_load_i) a_q <= bus_i;
      if (g_load_i) g_o <= result;
    end
  end

  // R7
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_load_i |=> $stable(a_q));
  // R7
  g_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !g_load_i |=> $stable(g_o));
endmodule

// File: rtl/busproc_busmux.sv
module busproc_busmux
  import busproc_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = REG_N
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [N-1:0][W-1:0] regs_i,
  input  logic [W-1:0]        g_i,
  input  logic [W-1:0]        ir_i,
  output logic [W-1:0]        bus_o
);
  localparam int AW = $clog2(N);

  always_comb begin
    bus_o = '0;
    if (sel_i < SEL_W'(N)) begin
      bus_o = regs_i[sel_i[AW-1:0]];
    end else begin
      case (sel_i)
        SEL_GREG:   bus_o = g_i;
        SEL_IMM9:   bus_o = imm_zext(ir_i[IMM_W-1:0]);
        SEL_IMMTOP: bus_o = imm_top(ir_i[BYTE_W-1:0]);
        default:    bus_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/busproc_ctrl.sv
module busproc_ctrl
  import busproc_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = REG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [W-1:0]     instr_i,
  output logic [W-1:0]     ir_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [N-1:0]     wr_en_o,
  output logic             a_load_o,
  output logic             g_load_o,
  output logic             sub_o,
  output logic             done_o
);
  localparam int AW = $clog2(N);

  step_e            step_q, step_d;
  opcode_e          op;
  logic             imm_flag;
  logic [AW-1:0]    rx, ry;
  logic             ir_load;
  logic             wr_dest;
  logic             arith;
  logic [SEL_W-1:0] opnd_sel;

  assign op       = opcode_e'(ir_o[15:13]);
  assign imm_flag = ir_o[12];
  assign rx       = ir_o[9 +: AW];
  assign ry       = ir_o[0 +: AW];
  assign arith    = (op == OP_ADD) || (op == OP_SUB);
  assign ir_load  = (step_q == ST_FETCH);
  assign opnd_sel = imm_flag ? SEL_IMM9 : SEL_W'(ry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
      ir_o   <= '0;
    end else begin
      step_q <= step_d;
      if (ir_load) ir_o <= instr_i;
    end
  end

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_FETCH: step_d = run_i ? ST_EX1 : ST_FETCH;
      ST_EX1:   step_d = arith ? ST_EX2 : ST_FETCH;
      ST_EX2:   step_d = ST_EX3;
      ST_EX3:   step_d = ST_FETCH;
      default:  step_d = ST_FETCH;
    endcase
  end

  always_comb begin
    sel_o    = '0;
    wr_dest  = 1'b0;
    a_load_o = 1'b0;
    g_load_o = 1'b0;
    sub_o    = 1'b0;
    done_o   = 1'b0;
    case (step_q)
      ST_EX1: begin
        case (op)
          OP_MOVE: begin
            sel_o   = opnd_sel;
            wr_dest = 1'b1;
            done_o  = 1'b1;
          end
          OP_MOVT: begin
            sel_o   = SEL_IMMTOP;
            wr_dest = 1'b1;
            done_o  = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            sel_o    = SEL_W'(rx);
            a_load_o = 1'b1;
          end
          default: done_o = 1'b1;
        endcase
      end
      ST_EX2: begin
        sel_o    = opnd_sel;
        g_load_o = 1'b1;
        sub_o    = (op == OP_SUB);
      end
      ST_EX3: begin
        sel_o   = SEL_GREG;
        wr_dest = 1'b1;
        done_o  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign wr_en_o[k] = wr_dest && (rx == AW'(k));
  end

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));
  // R2
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_FETCH && !run_i) |=> (step_q == ST_FETCH && wr_en_o == '0));
  // R10
  done_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (step_q == ST_FETCH));
  // R7
  wb_after_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_EX3) |-> $past(g_load_o));
  // R8
  sub_only_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o |-> g_load_o);
endmodule

// File: rtl/busproc16.sv
module busproc16
  import busproc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [WORD_W-1:0] instr_i,
  output logic              done_o,
  output logic [WORD_W-1:0] bus_o
);
  logic [WORD_W-1:0]            ir;
  logic [SEL_W-1:0]             sel;
  logic [REG_N-1:0]             wr_en;
  logic                         a_load, g_load, sub_mode;
  logic [REG_N-1:0][WORD_W-1:0] regs;
  logic [WORD_W-1:0]            g_val;

  busproc_ctrl #(.W(WORD_W), .N(REG_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .instr_i(instr_i),
    .ir_o(ir), .sel_o(sel), .wr_en_o(wr_en), .a_load_o(a_load),
    .g_load_o(g_load), .sub_o(sub_mode), .done_o(done_o)
  );

  busproc_regbank #(.W(WORD_W), .N(REG_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .bus_i(bus_o), .regs_o(regs)
  );

  busproc_alu #(.W(WORD_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .a_load_i(a_load), .g_load_i(g_load),
    .sub_i(sub_mode), .bus_i(bus_o), .g_o(g_val)
  );

  busproc_busmux #(.W(WORD_W), .N(REG_N)) u_mux (
    .sel_i(sel), .regs_i(regs), .g_i(g_val), .ir_i(ir), .bus_o(bus_o)
  );

  // R1
  reset_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done_o);
endmodule

// File: tb/busproc16_tb.sv
module busproc16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic        done_o;
  logic [15:0] bus_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];

  busproc16 u_dut (.clk(clk), .rst_n(rst_n), .run_i(run_i),
                   .instr_i(instr_i), .done_o(done_o), .bus_o(bus_o));

  always #4 clk = ~clk;

  // {instruction, expected write-back value, execute steps}
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {16'h101C, 16'h001C, 4'd1},  // R5 move r0,#28
    {16'h32FF, 16'hFF00, 4'd1},  // R6 move-top r1
    {16'h52FF, 16'hFFFF, 4'd3},  // R7 add r1,#0xFF
    {16'h6200, 16'hFFE3, 4'd3},  // R8 sub r1,r0
    {16'h5201, 16'hFFE4, 4'd3},  // R7 add r1,#1
    {16'h0401, 16'hFFE4, 4'd1},  // R4 move r2,r1
    {16'h1FFF, 16'h01FF, 4'd1},  // R5 move r7,#0x1FF
    {16'h4E07, 16'h03FE, 4'd3},  // R7 add r7,r7
    {16'h7601, 16'hFFFF, 4'd3},  // R8 sub r3,#1 wraps
    {16'h5601, 16'h0000, 4'd3},  // R7 add r3,#1 wraps
    {16'h39A5, 16'hA500, 4'd1},  // R6 move-top r4, bit 8 set
    {16'h0A04, 16'hA500, 4'd1},  // R4 move r5,r4
    {16'h6A02, 16'hA51C, 4'd3}   // R8 sub r5,r2
  };

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [15:0] ins, input logic [15:0] exp_res,
                      input int steps, input string tag);
    logic [2:0] rx;
    rx = ins[11:9];
    @(negedge clk);
    instr_i = ins;
    run_i = 1'b1;
    @(negedge clk);
    run_i = 1'b0;
    if (steps == 3) begin
      check(done_o == 1'b0, {tag, " R7 step1 done"}, 16'(done_o), 16'h0);
      check(bus_o == model[rx], {tag, " R7 step1 bus rX"}, bus_o, model[rx]);
      @(negedge clk);
      check(done_o == 1'b0, {tag, " R7 step2 done"}, 16'(done_o), 16'h0);
      @(negedge clk);
    end
    check(done_o == 1'b1, {tag, " done"}, 16'(done_o), 16'h1);
    check(bus_o == exp_res, {tag, " result"}, bus_o, exp_res);
    model[rx] = exp_res;
  endtask

  task automatic readback(input int k, input string tag);
    logic [15:0] w;
    w = {3'b000, 1'b0, 3'(k), 6'b0, 3'(k)};
    exec(w, model[k], 1, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    #20;
    check(done_o == 1'b0, "R1 done low in reset", 16'(done_o), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      exec(VEC[v][35:20], VEC[v][19:4], int'(VEC[v][3:0]), $sformatf("vec%0d", v));
    end

    // R3 R9 read every register back through a self move
    for (int k = 0; k < 8; k++) readback(k, $sformatf("R9 readback r%0d", k));

    // R2 run low: no progress, no register change
    @(negedge clk);
    instr_i = 16'h5201;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(done_o == 1'b0, "R2 idle done", 16'(done_o), 16'h0);
    end
    readback(1, "R2 r1 untouched");

    // R10 back-to-back instructions accepted
    exec(16'h1003, 16'h0003, 1, "R10 first");
    exec(16'h5001, 16'h0004, 3, "R10 second");

    // R1 reset in the middle of an add
    @(negedge clk);
    instr_i = 16'h5201;
    run_i = 1'b1;
    @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(done_o == 1'b0, "R1 done after mid reset", 16'(done_o), 16'h0);
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;
    readback(1, "R1 r1 cleared");
    readback(5, "R1 r5 cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule